// File: doc/BRIEF.md
# Transmit Cell Buffer with Whole-Cell Flow Control

This block sits between an ATM layer processor and the transmit framer of a physical-layer device. The processor writes cells over a UTOPIA-style bus: a data word, an odd-parity bit, an active-low write enable and a start-of-cell marker. The block answers with a cell-available line that promises room for one more complete cell. Cells are stored in a circular store of `CELL_SLOTS` cell slots. A simple read port hands them to the framer word by word, and only complete cells are ever offered.

Software controls four things through static inputs: how many slots may be used (a two-bit code), the cell size (52 or 53 bytes), the bus width (8 or 16 bits) and whether cells with a parity error are thrown away. A one-cycle flush strobe empties the store without touching the status or the configuration. Overflow and parity errors are held in sticky status bits. A status read strobe clears them, each bit has its own interrupt enable, and the enabled bits are combined into one interrupt line.

The write side is a three-state machine:
- `W_IDLE` waits for a start word. It moves to `W_CELL` (start accepted) when there is room, and to `W_DROP` (start refused) when there is none.
- `W_CELL` stores words. On the final word it returns to `W_IDLE` through the commit or discard transition.
- `W_DROP` swallows words. On the final word it returns to `W_IDLE` through the drop-done transition.

The read side has two states. `R_HEAD` is on the first word of the oldest cell and moves to `R_BODY` on the first read. `R_BODY` returns to `R_HEAD` on the read of the last word, which is the pop transition.

A flush sends both machines to their first state.

Top module: `utx_cell_fifo`

## Requirements
- R1: After reset the store is empty: `tx_clav`=1, `rd_cell_avail`=0, `st_ovf`=0, `st_perr`=0 and `irq`=0.
- R2: `cfg_depth` limits the usable cells (00→16, 01→12, 10→8, 11→4). `tx_clav` is 1 exactly while the occupied cells are fewer than that limit. A change takes effect in the same cycle.
- R3: A cell counts as occupied from the cycle after its start word is accepted. `tx_clav` may therefore fall in the middle of a cell, and the remaining words of that cell are still stored.
- R4: A cell is 27 words with `cfg_wide`=1 and `cfg_cell52`=0, 26 words with `cfg_wide`=1 and `cfg_cell52`=1, 53 words with `cfg_wide`=0 and `cfg_cell52`=0, and 52 words with `cfg_wide`=0 and `cfg_cell52`=1. In 8-bit mode only `tx_data[7:0]` is kept, and it is read back as {8'h00, byte}.
- R5: A partly written cell is never offered. `rd_cell_avail` rises in the cycle after the final word of the first stored cell is accepted.
- R6: A start word (`tx_enb_n`=0, `tx_soc`=1) that arrives when there is no room causes the whole cell to be dropped and sets `st_ovf`.
- R7: `tx_soc` is looked at only when no cell is in progress. Words accepted outside a cell without `tx_soc` are ignored.
- R8: `rd_data` shows the current word of the oldest stored cell. `rd_soc` marks its first word and `rd_eoc` its last. Each `rd_en` cycle advances one word, and cells leave in arrival order. `rd_en` while `rd_cell_avail`=0 has no effect.
- R9: Parity is odd. The XOR of `tx_prty` with `tx_data` (with `tx_data[7:0]` only in 8-bit mode) must be 1. Any accepted word of a cell that breaks this sets `st_perr`.
- R10: With `cfg_discard_perr`=1 a cell holding a parity-error word is not stored. With `cfg_discard_perr`=0 it is stored.
- R11: `flush` empties the store and abandons a cell in progress in the next cycle. `st_ovf` and `st_perr` keep their values.
- R12: `stat_rd` clears both sticky status bits in the next cycle. If a new error event arrives in the same cycle, the bit is set.
- R13: `irq` = (`st_ovf` AND `cfg_ovf_ie`) OR (`st_perr` AND `cfg_perr_ie`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Software flush strobe |
| cfg_depth | input | 2 | Operating depth code |
| cfg_cell52 | input | 1 | 1 = 52-byte cells, 0 = 53-byte cells |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_discard_perr | input | 1 | Discard cells with a parity error |
| cfg_ovf_ie | input | 1 | Overflow interrupt enable |
| cfg_perr_ie | input | 1 | Parity interrupt enable |
| stat_rd | input | 1 | Status read strobe (clears sticky bits) |
| tx_data | input | 16 | Write data word |
| tx_prty | input | 1 | Odd parity over the write data |
| tx_enb_n | input | 1 | Write enable, active low |
| tx_soc | input | 1 | Start-of-cell marker |
| tx_clav | output | 1 | Room for one more complete cell |
| rd_en | input | 1 | Read one word |
| rd_cell_avail | output | 1 | At least one complete cell stored |
| rd_data | output | 16 | Current read word |
| rd_soc | output | 1 | Current word is the first of its cell |
| rd_eoc | output | 1 | Current word is the last of its cell |
| st_ovf | output | 1 | Sticky overflow status |
| st_perr | output | 1 | Sticky parity-error status |
| irq | output | 1 | Interrupt |

## Verification
The bench builds the block with its default of 16 cell slots. This makes all four depth codes meaningful, from a 4-cell limit up to the full store. It also lets a run of 16 back-to-back cells wrap the slot pointers of both sides. All four cell-length combinations are driven at this size, so the word counter reaches both its 26-word and its 53-word end points.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int BUS_W      = 16;
    localparam int CELL_BYTES = 53;
    localparam int MAX_WORDS  = CELL_BYTES;

    typedef enum logic [1:0] {
        W_IDLE,
        W_CELL,
        W_DROP
    } wr_state_e;

    typedef enum logic {
        R_HEAD,
        R_BODY
    } rd_state_e;

    // usable cell slots for a two-bit limit code
    function automatic int depth_cells(input logic [1:0] code, input int slots);
        return slots - int'(code) * (slots / 4);
    endfunction

    // words per cell for the bus width and cell size selections
    function automatic int cell_words(input logic wide, input logic short52);
        int nbytes;
        nbytes = short52 ? CELL_BYTES - 1 : CELL_BYTES;
        return wide ? (nbytes + 1) / 2 : nbytes;
    endfunction

endpackage

// File: rtl/utx_cell_store.sv
module utx_cell_store
    import utx_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int AW = $clog2(SLOTS * MAX_WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [BUS_W-1:0] rdata
);
    localparam int NWORDS = SLOTS * MAX_WORDS;

    logic [BUS_W-1:0] mem [NWORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/utx_wr_ctrl.sv
module utx_wr_ctrl
    import utx_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int CW = $clog2(SLOTS + 1),
    localparam int AW = $clog2(SLOTS * MAX_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       cfg_depth,
    input  logic             cfg_wide,
    input  logic             cfg_cell52,
    input  logic             cfg_discard_perr,
    input  logic [BUS_W-1:0] tx_data,
    input  logic             tx_prty,
    input  logic             tx_enb_n,
    input  logic             tx_soc,
    input  logic             pop,
    output logic             tx_clav,
    output logic [CW-1:0]    cells_ready,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [BUS_W-1:0] mem_wdata,
    output logic             ovf_evt,
    output logic             perr_evt
);
    localparam int SW = $clog2(SLOTS);
    localparam int IW = $clog2(MAX_WORDS + 1);

    wr_state_e     st_q, st_d;
    logic [IW-1:0] idx_q, idx_d;
    logic [SW-1:0] slot_q;
    logic [CW-1:0] done_q;
    logic          bad_q, bad_d;
    logic [IW-1:0] wpc;
    logic [CW-1:0] limit;
    logic [CW:0]   occ;
    logic          acc, bad_now, room, last, commit;

    always_comb begin
        wpc     = IW'(cell_words(cfg_wide, cfg_cell52));
        limit   = CW'(depth_cells(cfg_depth, SLOTS));
        acc     = !tx_enb_n;
        bad_now = cfg_wide ? !(^{tx_data, tx_prty}) : !(^{tx_data[7:0], tx_prty});
        occ     = {1'b0, done_q} + {{CW{1'b0}}, (st_q == W_CELL)};
        room    = occ < {1'b0, limit};
        last    = (idx_q == wpc - IW'(1));
    end

    // next state
    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        bad_d  = bad_q;
        commit = 1'b0;
        unique case (st_q)
            W_IDLE: begin
                if (acc && tx_soc) begin
                    st_d  = room ? W_CELL : W_DROP;
                    idx_d = IW'(1);
                    bad_d = bad_now;
                end
            end
            W_CELL: begin
                if (acc) begin
                    if (last) begin
                        st_d   = W_IDLE;
                        idx_d  = '0;
                        bad_d  = 1'b0;
                        commit = !((bad_q || bad_now) && cfg_discard_perr);
                    end else begin
                        idx_d = idx_q + IW'(1);
                        bad_d = bad_q || bad_now;
                    end
                end
            end
            W_DROP: begin
                if (acc) begin
                    if (last) begin
                        st_d  = W_IDLE;
                        idx_d = '0;
                    end else begin
                        idx_d = idx_q + IW'(1);
                    end
                end
            end
            default: st_d = W_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= W_IDLE;
            idx_q  <= '0;
            bad_q  <= 1'b0;
            slot_q <= '0;
            done_q <= '0;
        end else if (flush) begin
            st_q   <= W_IDLE;
            idx_q  <= '0;
            bad_q  <= 1'b0;
            slot_q <= '0;
            done_q <= '0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            bad_q  <= bad_d;
            if (commit) begin
                slot_q <= (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
            end
            done_q <= done_q + CW'(commit) - CW'(pop);
        end
    end

    // outputs
    always_comb begin
        mem_we    = acc && (((st_q == W_IDLE) && tx_soc && room) || (st_q == W_CELL));
        mem_addr  = AW'(slot_q) * AW'(MAX_WORDS)
                  + ((st_q == W_IDLE) ? AW'(0) : AW'(idx_q));
        mem_wdata = cfg_wide ? tx_data : {{(BUS_W - 8){1'b0}}, tx_data[7:0]};
        ovf_evt   = acc && (st_q == W_IDLE) && tx_soc && !room;
        perr_evt  = acc && ((st_q != W_IDLE) || tx_soc) && bad_now;
        tx_clav   = room;
        cells_ready = done_q;
    end

    a_r6_refused_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (st_q == W_IDLE) && acc && tx_soc && !tx_clav) |=> (st_q == W_DROP))
        else $error("start word without room was not refused");

    a_r3_cell_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && (st_q == W_CELL) && acc && last && !cfg_discard_perr && !pop)
        |=> (done_q == $past(done_q) + CW'(1)))
        else $error("cell in progress was not committed");

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_q <= CW'(SLOTS))
        else $error("stored cell count beyond store size");

endmodule

// File: rtl/utx_rd_ctrl.sv
module utx_rd_ctrl
    import utx_pkg::*;
#(
    parameter int SLOTS = 16,
    localparam int CW = $clog2(SLOTS + 1),
    localparam int AW = $clog2(SLOTS * MAX_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          cfg_wide,
    input  logic          cfg_cell52,
    input  logic          rd_en,
    input  logic [CW-1:0] cells_ready,
    output logic          rd_cell_avail,
    output logic          rd_soc,
    output logic          rd_eoc,
    output logic          pop,
    output logic [AW-1:0] rd_addr
);
    localparam int SW = $clog2(SLOTS);
    localparam int IW = $clog2(MAX_WORDS + 1);

    rd_state_e     st_q, st_d;
    logic [IW-1:0] idx_q, idx_d, wpc;
    logic [SW-1:0] slot_q, slot_d;
    logic          take, last;

    always_comb begin
        wpc    = IW'(cell_words(cfg_wide, cfg_cell52));
        take   = rd_en && (cells_ready != '0);
        last   = (idx_q == wpc - IW'(1));
        st_d   = st_q;
        idx_d  = idx_q;
        slot_d = slot_q;
        unique case (st_q)
            R_HEAD: begin
                if (take) begin
                    st_d  = R_BODY;
                    idx_d = IW'(1);
                end
            end
            R_BODY: begin
                if (take) begin
                    if (last) begin
                        st_d   = R_HEAD;
                        idx_d  = '0;
                        slot_d = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
                    end else begin
                        idx_d = idx_q + IW'(1);
                    end
                end
            end
            default: st_d = R_HEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= R_HEAD;
            idx_q  <= '0;
            slot_q <= '0;
        end else if (flush) begin
            st_q   <= R_HEAD;
            idx_q  <= '0;
            slot_q <= '0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            slot_q <= slot_d;
        end
    end

    always_comb begin
        rd_cell_avail = (cells_ready != '0);
        rd_soc        = rd_cell_avail && (st_q == R_HEAD);
        rd_eoc        = rd_cell_avail && (st_q == R_BODY) && last;
        pop           = take && (st_q == R_BODY) && last;
        rd_addr       = AW'(slot_q) * AW'(MAX_WORDS) + AW'(idx_q);
    end

    a_r8_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_cell_avail && !flush) |=> ($stable(idx_q) && $stable(slot_q)))
        else $error("read while empty moved the read position");

    a_r8_pop_returns_to_head: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (st_q == R_HEAD))
        else $error("read of last word did not return to head");

endmodule

// File: rtl/utx_status.sv
module utx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic ovf_evt,
    input  logic perr_evt,
    input  logic cfg_ovf_ie,
    input  logic cfg_perr_ie,
    output logic st_ovf,
    output logic st_perr,
    output logic irq
);
    logic ovf_q, perr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            ovf_q  <= ovf_evt  || (ovf_q  && !stat_rd);
            perr_q <= perr_evt || (perr_q && !stat_rd);
        end
    end

    assign st_ovf  = ovf_q;
    assign st_perr = perr_q;
    assign irq     = (ovf_q && cfg_ovf_ie) || (perr_q && cfg_perr_ie);

    a_r12_ovf_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovf_evt) |=> !st_ovf)
        else $error("overflow status survived a status read");

    a_r12_perr_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !perr_evt) |=> !st_perr)
        else $error("parity status survived a status read");

    a_r6_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> st_ovf)
        else $error("overflow event not recorded");

    a_r9_perr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        perr_evt |=> st_perr)
        else $error("parity event not recorded");

endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
    import utx_pkg::*;
#(
    parameter int CELL_SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       cfg_depth,
    input  logic             cfg_cell52,
    input  logic             cfg_wide,
    input  logic             cfg_discard_perr,
    input  logic             cfg_ovf_ie,
    input  logic             cfg_perr_ie,
    input  logic             stat_rd,
    input  logic [BUS_W-1:0] tx_data,
    input  logic             tx_prty,
    input  logic             tx_enb_n,
    input  logic             tx_soc,
    output logic             tx_clav,
    input  logic             rd_en,
    output logic             rd_cell_avail,
    output logic [BUS_W-1:0] rd_data,
    output logic             rd_soc,
    output logic             rd_eoc,
    output logic             st_ovf,
    output logic             st_perr,
    output logic             irq
);
    localparam int CW = $clog2(CELL_SLOTS + 1);
    localparam int AW = $clog2(CELL_SLOTS * MAX_WORDS);

    logic [CW-1:0]    cells_ready;
    logic             pop, mem_we, ovf_evt, perr_evt;
    logic [AW-1:0]    mem_addr, rd_addr;
    logic [BUS_W-1:0] mem_wdata;

    utx_wr_ctrl #(.SLOTS(CELL_SLOTS)) u_wr (
        .clk              (clk),
        .rst_n            (rst_n),
        .flush            (flush),
        .cfg_depth        (cfg_depth),
        .cfg_wide         (cfg_wide),
        .cfg_cell52       (cfg_cell52),
        .cfg_discard_perr (cfg_discard_perr),
        .tx_data          (tx_data),
        .tx_prty          (tx_prty),
        .tx_enb_n         (tx_enb_n),
        .tx_soc           (tx_soc),
        .pop              (pop),
        .tx_clav          (tx_clav),
        .cells_ready      (cells_ready),
        .mem_we           (mem_we),
        .mem_addr         (mem_addr),
        .mem_wdata        (mem_wdata),
        .ovf_evt          (ovf_evt),
        .perr_evt         (perr_evt)
    );

    utx_cell_store #(.SLOTS(CELL_SLOTS)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    utx_rd_ctrl #(.SLOTS(CELL_SLOTS)) u_rd (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .cfg_wide      (cfg_wide),
        .cfg_cell52    (cfg_cell52),
        .rd_en         (rd_en),
        .cells_ready   (cells_ready),
        .rd_cell_avail (rd_cell_avail),
        .rd_soc        (rd_soc),
        .rd_eoc        (rd_eoc),
        .pop           (pop),
        .rd_addr       (rd_addr)
    );

    utx_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_rd     (stat_rd),
        .ovf_evt     (ovf_evt),
        .perr_evt    (perr_evt),
        .cfg_ovf_ie  (cfg_ovf_ie),
        .cfg_perr_ie (cfg_perr_ie),
        .st_ovf      (st_ovf),
        .st_perr     (st_perr),
        .irq         (irq)
    );

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rd_cell_avail && tx_clav))
        else $error("flush left cells behind");

endmodule

// File: tb/utx_cell_fifo_tb.sv
`timescale 1ns/1ps
module utx_cell_fifo_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  cfg_depth = 2'b00;
    logic        cfg_cell52 = 1'b0;
    logic        cfg_wide = 1'b1;
    logic        cfg_discard_perr = 1'b0;
    logic        cfg_ovf_ie = 1'b0;
    logic        cfg_perr_ie = 1'b0;
    logic        stat_rd = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_prty = 1'b0;
    logic        tx_enb_n = 1'b1;
    logic        tx_soc = 1'b0;
    logic        rd_en = 1'b0;
    logic        tx_clav, rd_cell_avail, rd_soc, rd_eoc, st_ovf, st_perr, irq;
    logic [15:0] rd_data;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;
    bit  strobe_on_first = 1'b0;

    always #4 clk = ~clk;

    utx_cell_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_depth(cfg_depth),
        .cfg_cell52(cfg_cell52), .cfg_wide(cfg_wide),
        .cfg_discard_perr(cfg_discard_perr), .cfg_ovf_ie(cfg_ovf_ie),
        .cfg_perr_ie(cfg_perr_ie), .stat_rd(stat_rd), .tx_data(tx_data),
        .tx_prty(tx_prty), .tx_enb_n(tx_enb_n), .tx_soc(tx_soc),
        .tx_clav(tx_clav), .rd_en(rd_en), .rd_cell_avail(rd_cell_avail),
        .rd_data(rd_data), .rd_soc(rd_soc), .rd_eoc(rd_eoc),
        .st_ovf(st_ovf), .st_perr(st_perr), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int          m_st;      // 0 idle, 1 storing, 2 dropping
    int          m_idx;
    bit          m_bad;
    logic [15:0] m_cur[$];
    logic [15:0] m_words[$];
    int          m_ncells;
    int          m_ridx;
    bit          m_ovf, m_perr;

    function automatic int b_wpc();
        int nb;
        nb = cfg_cell52 ? 52 : 53;
        return cfg_wide ? (nb + 1) / 2 : nb;
    endfunction

    function automatic int b_depth();
        return 16 - 4 * int'(cfg_depth);
    endfunction

    always @(posedge clk) begin : model
        int          wpc;
        bit          room, acc, bad, ovf_e, perr_e;
        logic [15:0] wd;
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_bad = 0; m_cur.delete(); m_words.delete();
            m_ncells = 0; m_ridx = 0; m_ovf = 0; m_perr = 0;
        end else begin
            wpc    = b_wpc();
            room   = (m_ncells + ((m_st == 1) ? 1 : 0)) < b_depth();
            acc    = !tx_enb_n;
            bad    = cfg_wide ? ((^{tx_data, tx_prty}) == 1'b0)
                              : ((^{tx_data[7:0], tx_prty}) == 1'b0);
            wd     = cfg_wide ? tx_data : {8'h00, tx_data[7:0]};
            ovf_e  = 0;
            perr_e = 0;
            if (rd_en && m_ncells > 0) begin
                void'(m_words.pop_front());
                if (m_ridx == wpc - 1) begin
                    m_ridx = 0;
                    m_ncells--;
                end else begin
                    m_ridx++;
                end
            end
            if (acc) begin
                if (m_st == 0) begin
                    if (tx_soc) begin
                        perr_e = bad;
                        if (room) begin
                            m_st = 1; m_cur.delete(); m_cur.push_back(wd); m_bad = bad;
                        end else begin
                            m_st = 2; ovf_e = 1;
                        end
                        m_idx = 1;
                    end
                end else begin
                    perr_e = bad;
                    if (m_st == 1) begin
                        m_cur.push_back(wd);
                        m_bad = m_bad | bad;
                    end
                    if (m_idx == wpc - 1) begin
                        if (m_st == 1 && !(m_bad && cfg_discard_perr)) begin
                            foreach (m_cur[k]) m_words.push_back(m_cur[k]);
                            m_ncells++;
                        end
                        m_st = 0; m_idx = 0;
                    end else begin
                        m_idx++;
                    end
                end
            end
            if (flush) begin
                m_st = 0; m_idx = 0; m_bad = 0; m_words.delete(); m_ncells = 0; m_ridx = 0;
            end
            m_ovf  = ovf_e  | (m_ovf  & !stat_rd);
            m_perr = perr_e | (m_perr & !stat_rd);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            chk("R2 tx_clav", 32'(tx_clav),
                32'((m_ncells + ((m_st == 1) ? 1 : 0)) < b_depth()));
            chk("R5 rd_cell_avail", 32'(rd_cell_avail), 32'(m_ncells > 0));
            if (m_ncells > 0) begin
                chk("R8 rd_data", 32'(rd_data), 32'(m_words[0]));
                chk("R8 rd_soc", 32'(rd_soc), 32'(m_ridx == 0));
                chk("R8 rd_eoc", 32'(rd_eoc), 32'(m_ridx == b_wpc() - 1));
            end
            chk("R6 st_ovf", 32'(st_ovf), 32'(m_ovf));
            chk("R9 st_perr", 32'(st_perr), 32'(m_perr));
            chk("R13 irq", 32'(irq), 32'((m_ovf && cfg_ovf_ie) || (m_perr && cfg_perr_ie)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_words(input int seed, input int start, input int cnt, input int bad_at);
        logic [15:0] d;
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            d        = 16'(seed * 97 + (start + i) * 5 + 3);
            tx_data  = d;
            tx_prty  = (cfg_wide ? ~^d : ~^d[7:0]) ^ ((start + i) == bad_at);
            tx_enb_n = 1'b0;
            tx_soc   = ((start + i) == 0);
            stat_rd  = strobe_on_first && ((start + i) == 0);
        end
        @(negedge clk);
        tx_enb_n = 1'b1;
        tx_soc   = 1'b0;
        stat_rd  = 1'b0;
        #2;
    endtask

    task automatic send_cell(input int seed, input int bad_at);
        send_words(seed, 0, b_wpc(), bad_at);
    endtask

    task automatic read_words(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            rd_en = 1'b1;
        end
        @(negedge clk);
        rd_en = 1'b0;
        #2;
    endtask

    task automatic pulse_status_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        #2;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        #2;
    endtask

    task automatic set_depth(input logic [1:0] code);
        @(negedge clk); cfg_depth = code;
        #2;
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1 reset state
        chk("R1 tx_clav", 32'(tx_clav), 1);
        chk("R1 rd_cell_avail", 32'(rd_cell_avail), 0);
        chk("R1 st_ovf", 32'(st_ovf), 0);
        chk("R1 st_perr", 32'(st_perr), 0);
        chk("R1 irq", 32'(irq), 0);

        // R8 read while empty has no effect
        read_words(3);
        chk("R8 empty read", 32'(rd_cell_avail), 0);

        // R5 partial cell hidden, whole cell shown
        send_words(1, 0, 10, -1);
        chk("R5 partial hidden", 32'(rd_cell_avail), 0);
        send_words(1, 10, b_wpc() - 10, -1);
        chk("R5 complete shown", 32'(rd_cell_avail), 1);
        chk("R8 first word soc", 32'(rd_soc), 1);
        read_words(b_wpc());
        chk("R8 drained", 32'(rd_cell_avail), 0);

        // R2 / R3 four-cell limit, clav falls mid-cell
        set_depth(2'b11);
        for (int c = 0; c < 3; c++) send_cell(10 + c, -1);
        chk("R2 three of four", 32'(tx_clav), 1);
        send_words(13, 0, 1, -1);
        chk("R3 clav low mid cell", 32'(tx_clav), 0);
        send_words(13, 1, b_wpc() - 1, -1);
        chk("R3 cell finished", 32'(tx_clav), 0);

        // R6 overflow, R13 irq
        cfg_ovf_ie = 1'b1;
        send_cell(14, -1);
        chk("R6 overflow set", 32'(st_ovf), 1);
        chk("R13 irq on overflow", 32'(irq), 1);
        pulse_status_read();
        chk("R12 read clears", 32'(st_ovf), 0);
        chk("R13 irq cleared", 32'(irq), 0);
        strobe_on_first = 1'b1;
        send_cell(15, -1);
        strobe_on_first = 1'b0;
        chk("R12 event wins over read", 32'(st_ovf), 1);
        pulse_status_read();

        // R2 run-time depth changes
        set_depth(2'b00);
        chk("R2 depth 16", 32'(tx_clav), 1);
        set_depth(2'b10);
        for (int c = 0; c < 4; c++) send_cell(20 + c, -1);
        chk("R2 depth 8 full", 32'(tx_clav), 0);
        set_depth(2'b01);
        chk("R2 depth 12", 32'(tx_clav), 1);
        read_words(8 * b_wpc());
        chk("R8 all eight read", 32'(rd_cell_avail), 0);

        // R2 full store, pointer wrap
        set_depth(2'b00);
        for (int c = 0; c < 16; c++) send_cell(30 + c, -1);
        chk("R2 sixteen full", 32'(tx_clav), 0);
        read_words(16 * b_wpc());
        chk("R8 sixteen read", 32'(rd_cell_avail), 0);

        // R9 / R10 parity
        cfg_perr_ie = 1'b1;
        send_cell(50, 5);
        chk("R9 parity status", 32'(st_perr), 1);
        chk("R10 kept when allowed", 32'(rd_cell_avail), 1);
        read_words(b_wpc());
        pulse_status_read();
        chk("R12 parity cleared", 32'(st_perr), 0);
        cfg_discard_perr = 1'b1;
        send_cell(51, b_wpc() - 1);
        chk("R10 discarded", 32'(rd_cell_avail), 0);
        chk("R9 parity on last word", 32'(st_perr), 1);
        chk("R13 irq on parity", 32'(irq), 1);
        cfg_discard_perr = 1'b0;

        // R11 flush, R7 stray words
        send_cell(60, -1);
        send_cell(61, -1);
        send_words(62, 0, 5, -1);
        pulse_flush();
        chk("R11 flushed", 32'(rd_cell_avail), 0);
        chk("R11 room back", 32'(tx_clav), 1);
        chk("R11 status kept", 32'(st_perr), 1);
        send_words(62, 5, 10, -1);
        chk("R7 stray words ignored", 32'(rd_cell_avail), 0);
        chk("R7 no occupancy", 32'(tx_clav), 1);
        send_cell(63, -1);
        chk("R7 next cell stored", 32'(rd_cell_avail), 1);
        read_words(b_wpc());

        // R4 cell lengths
        cfg_wide = 1'b0;
        send_words(70, 0, 52, -1);
        chk("R4 narrow 53 not yet", 32'(rd_cell_avail), 0);
        send_words(70, 52, 1, -1);
        chk("R4 narrow 53 done", 32'(rd_cell_avail), 1);
        chk("R4 narrow upper byte", 32'(rd_data[15:8]), 0);
        read_words(53);
        cfg_cell52 = 1'b1;
        send_cell(71, -1);
        chk("R4 narrow 52 done", 32'(rd_cell_avail), 1);
        read_words(52);
        cfg_wide = 1'b1;
        send_words(72, 0, 25, -1);
        chk("R4 wide 52 not yet", 32'(rd_cell_avail), 0);
        send_words(72, 25, 1, -1);
        chk("R4 wide 52 done", 32'(rd_cell_avail), 1);
        read_words(26);
        chk("R4 wide 52 drained", 32'(rd_cell_avail), 0);

        repeat (3) @(negedge clk);
        report();
    end

endmodule